// File: doc/BRIEF.md
# Prescaled timer counter channel

One 16-bit counting channel for a system timer. A divider built from power-of-two stages turns the input clock into count ticks. On each tick the count moves up or down by one. The count wraps either at the natural 16-bit limit or at a programmable interval.

The count is compared with three match values. Wraps and matches set sticky status flags, which stay set until the register side sends a clear strobe. The channel holds its own counter-control and clock-control registers, which the register side writes with one-cycle strobes. Interval and match values come in as plain inputs.

Counter-control bits:

| Bit | Meaning |
|---|---|
| 0 | Disable |
| 1 | Interval mode |
| 2 | Down-count |
| 3 | Match enable |
| 4 | Zero request |
| 5 | Stored and read back |

Clock-control bits:

| Bit | Meaning |
|---|---|
| 0 | Divider enable |
| 4:1 | Divider select N |

Status flags:

| Bit | Meaning |
|---|---|
| 0 | Interval wrap |
| 1 to 3 | Matches 1 to 3 |
| 4 | Overflow wrap |
| 5 | Reserved event flag, never set here |

Top module: `tick_timer_chan`

## Requirements
- R1: After reset, counter control reads 0x21, the count is 0 and all six flags are 0.
- R2: A counter-control write with bit4 set forces the count to 0 at that edge, with no tick in that cycle. The other written bits are stored, and bit4 always reads back 0.
- R3: With clock-control bit0 set and select value N in bits[4:1], the count advances once every 2^(N+1) clocks. With bit0 clear, it advances every clock. A clock-control write or a zero request restarts the divider, so the first tick after it comes a full period later.
- R4: Counting up in interval mode (bit1) runs 0 to the interval value, then back to 0. Without interval mode it runs 0 to 0xFFFF, then back to 0.
- R5: In down mode (bit2), the count steps down by one per tick. From 0 it loads the top value of the active period: the interval value, or 0xFFFF.
- R6: Every wrap sets flag bit0 when interval mode is on, and flag bit4 when it is off.
- R7: With match enable (bit3) set, a tick that loads a count equal to match value k sets flag bit k (k = 1..3). Match value k sits in bits [16k-1:16(k-1)] of the match bus.
- R8: A match value above the active top value never sets its flag.
- R9: Flags are sticky until the clear strobe, and flag bit5 is never set.
- R10: When the clear strobe and a new flag arrive in the same cycle, the result is exactly the new flag; every older flag is cleared.
- R11: With match enable clear, no match flag is set, even when the count passes a match value.
- R12: While bit0 (disable) is set, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctrl_wr_i | input | 1 | Clock-control write strobe |
| clk_ctrl_wdata_i | input | 5 | Clock control: bit0 divider enable, bits[4:1] select N |
| cnt_ctrl_wr_i | input | 1 | Counter-control write strobe |
| cnt_ctrl_wdata_i | input | 6 | Counter-control write data |
| cnt_ctrl_o | output | 6 | Stored counter control |
| interval_i | input | 16 | Interval value (top in interval mode) |
| match_i | input | 48 | Three packed match values, match 1 in the low bits |
| flag_clr_i | input | 1 | Clears all flags for one cycle |
| count_o | output | 16 | Current count |
| flags_o | output | 6 | Sticky status flags |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Divider restart.** A divider that is not restarted on a write would give a short first period. With divide-by-four selected, this moves the first tick earlier than the fourth clock.
- **Down-count from zero.** A design that takes the 16-bit limit instead of the interval would read 0xFFFF where 4 is expected.
- **Out-of-range match value.** A comparator that does not check against the active top value would set the flag of a value above the interval.
- **Clear and match in one cycle.** If the clear strobe wins, the new match flag is lost. If it is ignored, stale wrap and match flags survive the clear.
- **Random programming.** Random writes of control, interval and match values, mixed with clears, are compared every cycle against a bench model of the period, wrap and match rules.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  // counter control bit positions
  localparam int CC_W     = 6;
  localparam int CC_OFF   = 0;
  localparam int CC_IVL   = 1;
  localparam int CC_DOWN  = 2;
  localparam int CC_MEN   = 3;
  localparam int CC_ZERO  = 4;
  localparam logic [CC_W-1:0] CC_RESET = 6'h21;
endpackage

// File: rtl/ttc_prescale.sv
module ttc_prescale #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] sel,
  input  logic            run,
  input  logic            clear,
  output logic            tick
);
  localparam int DIV_W = 1 << PS_W;

  // terminal count of a 2^(sel+1) divider: sel+1 low ones
  function automatic logic [DIV_W-1:0] limit_of(input logic [PS_W-1:0] s);
    logic [DIV_W-1:0] t;
    for (int i = 0; i < DIV_W; i++) t[i] = (i <= int'(s));
    return t;
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             hit;

  assign hit  = en ? (div_q == limit_of(sel)) : 1'b1;
  assign tick = run & ~clear & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (clear || !en)  div_q <= '0;
    else if (run)           div_q <= hit ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/ttc_counter.sv
module ttc_counter #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       zero,
  input  logic                       ivl_mode,
  input  logic                       down,
  input  logic                       match_en,
  input  logic [CNT_W-1:0]           interval,
  input  logic [NUM_MATCH*CNT_W-1:0] match_vals,
  output logic [CNT_W-1:0]           count,
  output logic                       wrap,
  output logic [NUM_MATCH-1:0]       match_hit
);
  localparam logic [CNT_W-1:0] FULL = '1;

  // returns {wrapped, next count}
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] top,
                                             input logic dn);
    if (dn) return (cur == '0) ? {1'b1, top} : {1'b0, cur - 1'b1};
    else    return (cur >= top) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cur + 1'b1};
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] top;
  logic [CNT_W:0]   step;

  assign top   = ivl_mode ? interval : FULL;
  assign step  = advance(count_q, top, down);
  assign wrap  = tick & step[CNT_W];
  assign count = count_q;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
    logic [CNT_W-1:0] mv;
    assign mv = match_vals[k*CNT_W +: CNT_W];
    assign match_hit[k] = tick & match_en & (step[CNT_W-1:0] == mv) & (mv <= top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (zero) count_q <= '0;
    else if (tick) count_q <= step[CNT_W-1:0];
  end
endmodule

// File: rtl/ttc_flags.sv
module ttc_flags #(
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set,
  input  logic              clr,
  output logic [FLAG_W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set;
  end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import ttc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3,
  parameter int PS_W      = 4,
  localparam int CLK_W    = PS_W + 1,
  localparam int FLAG_W   = NUM_MATCH + 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clk_ctrl_wr_i,
  input  logic [CLK_W-1:0]           clk_ctrl_wdata_i,
  input  logic                       cnt_ctrl_wr_i,
  input  logic [CC_W-1:0]            cnt_ctrl_wdata_i,
  output logic [CC_W-1:0]            cnt_ctrl_o,
  input  logic [CNT_W-1:0]           interval_i,
  input  logic [NUM_MATCH*CNT_W-1:0] match_i,
  input  logic                       flag_clr_i,
  output logic [CNT_W-1:0]           count_o,
  output logic [FLAG_W-1:0]          flags_o
);
  localparam int OV_BIT = NUM_MATCH + 1;

  logic [CC_W-1:0]      cnt_ctrl_q;
  logic [CLK_W-1:0]     clk_ctrl_q;
  logic                 zero_req;
  logic                 ps_clear;
  logic                 tick;
  logic                 wrap;
  logic [NUM_MATCH-1:0] match_hit;
  logic [FLAG_W-1:0]    flag_set;

  assign zero_req = cnt_ctrl_wr_i & cnt_ctrl_wdata_i[CC_ZERO];
  assign ps_clear = clk_ctrl_wr_i | zero_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_ctrl_q <= CC_RESET;
      clk_ctrl_q <= '0;
    end else begin
      if (cnt_ctrl_wr_i) cnt_ctrl_q <= cnt_ctrl_wdata_i & ~(CC_W'(1) << CC_ZERO);
      if (clk_ctrl_wr_i) clk_ctrl_q <= clk_ctrl_wdata_i;
    end
  end

  ttc_prescale #(.PS_W(PS_W)) u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (clk_ctrl_q[0]),
    .sel   (clk_ctrl_q[PS_W:1]),
    .run   (~cnt_ctrl_q[CC_OFF]),
    .clear (ps_clear),
    .tick  (tick)
  );

  ttc_counter #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .zero       (zero_req),
    .ivl_mode   (cnt_ctrl_q[CC_IVL]),
    .down       (cnt_ctrl_q[CC_DOWN]),
    .match_en   (cnt_ctrl_q[CC_MEN]),
    .interval   (interval_i),
    .match_vals (match_i),
    .count      (count_o),
    .wrap       (wrap),
    .match_hit  (match_hit)
  );

  always_comb begin
    flag_set = '0;
    flag_set[0]             = wrap & cnt_ctrl_q[CC_IVL];
    flag_set[NUM_MATCH:1]   = match_hit;
    flag_set[OV_BIT]        = wrap & ~cnt_ctrl_q[CC_IVL];
  end

  ttc_flags #(.FLAG_W(FLAG_W)) u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr_i),
    .flags (flags_o)
  );

  assign cnt_ctrl_o = cnt_ctrl_q;
endmodule

// File: rtl/ttc_chan_chk.sv
module ttc_chan_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3,
  localparam int FLAG_W   = NUM_MATCH + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_ctrl_wr_i,
  input logic [5:0]        cnt_ctrl_wdata_i,
  input logic [5:0]        cnt_ctrl_o,
  input logic [CNT_W-1:0]  interval_i,
  input logic              flag_clr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              tick
);
  // R2
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ctrl_wr_i && cnt_ctrl_wdata_i[4] |=> count_o == '0);

  // R2
  zero_bit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ctrl_o[4] == 1'b0);

  // R12
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ctrl_o[0] && !cnt_ctrl_wr_i |=> $stable(count_o));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o));

  // R9
  event_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[FLAG_W-1] == 1'b0);

  // R11
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ctrl_o[3] |=> (flags_o[NUM_MATCH:1] & ~$past(flags_o[NUM_MATCH:1])) == '0);

  // R4
  interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt_ctrl_o[1] && !cnt_ctrl_o[2] && count_o >= interval_i |=> count_o == '0);
endmodule

bind tick_timer_chan ttc_chan_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cnt_ctrl_wr_i    (cnt_ctrl_wr_i),
  .cnt_ctrl_wdata_i (cnt_ctrl_wdata_i),
  .cnt_ctrl_o       (cnt_ctrl_o),
  .interval_i       (interval_i),
  .flag_clr_i       (flag_clr_i),
  .count_o          (count_o),
  .flags_o          (flags_o),
  .tick             (tick)
);

// File: tb/tick_timer_chan_tb.sv
`timescale 1ns/1ps
module tick_timer_chan_tb;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_wr = 1'b0;
  logic [4:0]  clk_data = '0;
  logic        cnt_wr = 1'b0;
  logic [5:0]  cnt_data = '0;
  logic [5:0]  ctrl_rd;
  logic [15:0] interval = '0;
  logic [47:0] match = '0;
  logic        clr = 1'b0;
  logic [15:0] count;
  logic [5:0]  flags;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  tick_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n),
    .clk_ctrl_wr_i(clk_wr), .clk_ctrl_wdata_i(clk_data),
    .cnt_ctrl_wr_i(cnt_wr), .cnt_ctrl_wdata_i(cnt_data), .cnt_ctrl_o(ctrl_rd),
    .interval_i(interval), .match_i(match), .flag_clr_i(flag_clr_w),
    .count_o(count), .flags_o(flags)
  );
  wire flag_clr_w = clr;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, stated from the requirements
  logic [5:0]  m_ctrl;
  logic [4:0]  m_clk;
  int          m_ps;
  logic [15:0] m_cnt;
  logic [5:0]  m_flags;

  function automatic int period_of(input logic [4:0] c);
    return c[0] ? (2 << c[4:1]) : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 6'h21; m_clk = '0; m_ps = 0; m_cnt = '0; m_flags = '0;
    end else begin
      bit restart, go, zero;
      logic [15:0] top;
      logic [5:0]  newf;
      zero    = cnt_wr && cnt_data[4];
      restart = clk_wr || zero;
      go      = !m_ctrl[0] && !restart && (m_ps + 1 >= period_of(m_clk));
      top     = m_ctrl[1] ? interval : 16'hFFFF;
      newf    = '0;
      if (restart || m_ctrl[0]) m_ps = restart ? 0 : m_ps;
      else m_ps = go ? 0 : m_ps + 1;
      if (zero) m_cnt = '0;
      else if (go) begin
        bit w;
        w = m_ctrl[2] ? (m_cnt == 0) : (m_cnt >= top);
        if (m_ctrl[2]) m_cnt = w ? top : m_cnt - 16'd1;
        else           m_cnt = w ? 16'd0 : m_cnt + 16'd1;
        if (w) newf[m_ctrl[1] ? 0 : 4] = 1'b1;
        if (m_ctrl[3])
          for (int k = 0; k < 3; k++)
            if (match[k*16 +: 16] <= top && match[k*16 +: 16] == m_cnt) newf[k+1] = 1'b1;
      end
      m_flags = (clr ? 6'h00 : m_flags) | newf;
      if (cnt_wr) m_ctrl = cnt_data & 6'h2F;
      if (clk_wr) m_clk = clk_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R4 model count", count, m_cnt);
      chk("R7 model flags", flags, m_flags);
      chk("R2 model ctrl readback", ctrl_rd, m_ctrl);
    end
  end

  // ---------------- stimulus helpers (start and end just after a falling edge)
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_cnt(input logic [5:0] v);
    cnt_wr = 1'b1; cnt_data = v; @(negedge clk); cnt_wr = 1'b0;
  endtask
  task automatic wr_clk(input logic [4:0] v);
    clk_wr = 1'b1; clk_data = v; @(negedge clk); clk_wr = 1'b0;
  endtask
  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4711));
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ctrl after reset", ctrl_rd, 6'h21);
    chk("R1 count after reset", count, 0);
    chk("R1 flags after reset", flags, 0);
    cmp_en = 1'b1;

    // R2: zero request, bit4 not stored, count starts
    wr_cnt(6'h10);
    chk("R2 ctrl bit4 hidden", ctrl_rd, 6'h00);
    chk("R2 count zeroed", count, 0);
    cycles(5);
    chk("R2 count runs", count, 5);

    // R3: divide by four, restarted by writes
    wr_clk(5'h03);
    wr_cnt(6'h10);
    cycles(3);
    chk("R3 no tick before period", count, 0);
    cycles(1);
    chk("R3 first tick", count, 1);
    cycles(4);
    chk("R3 second tick", count, 2);
    wr_clk(5'h00);

    // R4 / R6: interval up-count
    interval = 16'd4;
    pulse_clr();
    wr_cnt(6'h12);
    cycles(4);
    chk("R4 reaches interval", count, 4);
    cycles(1);
    chk("R4 wraps to zero", count, 0);
    chk("R6 interval flag", flags, 6'h01);

    // R5: down count from zero loads interval
    wr_cnt(6'h16);
    cycles(1);
    chk("R5 down loads top", count, 4);
    cycles(1);
    chk("R5 down steps", count, 3);

    // R6: free-running down wrap sets overflow flag
    pulse_clr();
    wr_cnt(6'h14);
    cycles(1);
    chk("R5 free down loads 0xFFFF", count, 16'hFFFF);
    chk("R6 overflow flag", flags, 6'h10);

    // R7 / R8: matches at 2 and 6, 9 is above interval 6
    interval = 16'd6;
    match = {16'd6, 16'd9, 16'd2};
    pulse_clr();
    wr_cnt(6'h1A);
    cycles(2);
    chk("R7 match1 count", count, 2);
    chk("R7 match1 flag", flags, 6'h02);
    cycles(4);
    chk("R7 match3 flag", flags, 6'h0A);
    cycles(1);
    chk("R6 wrap flag added", flags, 6'h0B);
    cycles(9);
    chk("R8 match above top silent", flags, 6'h0B);

    // R10: clear in the cycle match1 fires
    cycles(6);
    chk("R10 setup count", count, 1);
    pulse_clr();
    chk("R10 new flag wins over clear", flags, 6'h02);

    // R11: match disabled
    wr_cnt(6'h12);
    pulse_clr();
    cycles(7);
    chk("R11 no match flags", flags, 6'h01);

    // R12: disable holds count
    wr_cnt(6'h01);
    held = count;
    cycles(5);
    chk("R12 count held", count, held);

    // random phase, checked by the model every cycle
    pulse_clr();
    for (int i = 0; i < 4000; i++) begin
      cnt_wr   = ($urandom % 16 == 0);
      cnt_data = 6'($urandom);
      if ($urandom % 4 != 0) cnt_data[0] = 1'b0;
      clk_wr   = ($urandom % 64 == 0);
      clk_data = {4'($urandom % 3), 1'($urandom)};
      clr      = ($urandom % 32 == 0);
      if ($urandom % 50 == 0) interval = 16'($urandom % 40);
      if ($urandom % 50 == 0) match = {16'($urandom % 40), 16'($urandom % 40), 16'($urandom % 40)};
      @(negedge clk);
    end
    cnt_wr = 1'b0; clk_wr = 1'b0; clr = 1'b0;
    @(negedge clk);
    // R9
    chk("R9 event bit never set", flags[5], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule